// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a simple request port and a 256K x 4 page-mode DRAM. Each request carries an 18-bit word address, a read/write flag and 4 bits of write data, and is accepted through a valid/ready handshake. The controller drives the row strobe, column strobe, write enable, output enable and the 9-bit multiplexed address. The upper 9 address bits select the row and the lower 9 bits select the column.

The controller keeps a row open after an access. When later requests fall in the same row, it issues further column cycles paced by the page cycle rather than by the full random cycle. It closes the row on a row miss, after an idle period, when a refresh grant arrives, or before the row strobe has been low for its maximum allowed time. Every timing limit is a nanosecond parameter that is turned into a clock count at elaboration. Read data is returned with a one-cycle valid pulse, in request order. Writes are early writes and produce no response.

Top module: `page_dram_ctrl`

## Requirements
- R1: After reset, all four strobes (ras_n, cas_n, we_n, oe_n) are high, dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A row opens with ras_n falling while ma carries address bits [17:9]. ma switches to address bits [8:0] no earlier than the row-hold count, and cas_n falls at least 2 cycles (20 ns) after ras_n falls.
- R3: Requests that hit the open row are served by repeated column cycles without raising ras_n, so a burst to one row costs one activation.
- R4: Each column cycle holds cas_n low for at least 3 cycles. Successive cas_n falls within one row are at least 3 cycles apart.
- R5: A row miss raises ras_n and reopens the new row. ras_n stays low at least 5 cycles and high at least 3 cycles, and successive ras_n falls are at least 8 cycles apart.
- R6: ras_n never stays low longer than the page-mode limit (200 cycles in the bench configuration). A longer run of hits is split across activations.
- R7: An open row with no pending request is held for the idle timeout (20 cycles) and then closed.
- R8: A write is an early write. we_n is low and dq_oe is 1, with the data on dq_out, from the cas_n fall until the cas_n rise, while oe_n stays high. The data lands at the addressed word.
- R9: A read drives oe_n low with dq_oe 0, captures dq_in at the end of the cas_n low time, and returns it with a single-cycle rsp_valid. Responses come back in request order.
- R10: While ref_grant is 1, req_ready is 0. An open row is closed within 12 cycles, and no row is opened until the grant drops. Accepted work then resumes.
- R11: dq_oe is never 1 while oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, [17:9] row, [8:0] column |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 4 | Read data |
| ref_grant | input | 1 | Refresh owns the memory; controller yields |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| ma | output | 9 | Multiplexed row/column address |
| dq_out | output | 4 | Write data to memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 4 | Read data from memory |

## Verification
A corrupted open-row register causes hits to be served in the wrong row. The error shows as a read-back mismatch on the first later read of that data. Bad state or counter values break strobe spacing, and the pin monitor measures that spacing at the very next edge: ras_n fall to cas_n fall, precharge length, cas_n low time and the ras_n low run. A wrong hit/miss or close decision shows up as a changed activation count over a known burst, or as ras_n at the wrong level at a fixed number of cycles after the last request or after the refresh grant.

// File: rtl/page_dram_ctrl.sv
`timescale 1ns/1ps
module page_dram_ctrl #(
  parameter int MA_W    = 9,
  parameter int DQ_W    = 4,
  parameter int CLK_NS  = 10,
  parameter int RAH_NS  = 8,
  parameter int RCD_NS  = 13,
  parameter int RAS_NS  = 45,
  parameter int RASP_NS = 100000,
  parameter int RP_NS   = 25,
  parameter int RC_NS   = 80,
  parameter int CAS_NS  = 15,
  parameter int CP_NS   = 10,
  parameter int PC_NS   = 30,
  parameter int CAC_NS  = 15,
  parameter int AA_NS   = 25,
  parameter int IDLE_NS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_rdata,
  input  logic              ref_grant,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [MA_W-1:0]   ma,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  input  logic [DQ_W-1:0]   dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AW     = 2 * MA_W;
  localparam int T_RAH  = cyc(RAH_NS);
  localparam int T_RCD  = imax(cyc(RCD_NS), T_RAH + 1);
  localparam int T_RAS  = cyc(RAS_NS);
  localparam int T_RP   = cyc(RP_NS);
  localparam int T_RC   = cyc(RC_NS);
  localparam int T_CP   = cyc(CP_NS);
  localparam int T_ACC  = imax(cyc(CAC_NS), cyc(AA_NS));
  localparam int T_COL  = imax(imax(cyc(CAS_NS), cyc(PC_NS) - T_CP), T_ACC);
  localparam int T_RASP = RASP_NS / CLK_NS;
  localparam int T_LIM  = T_RASP - (T_COL + T_CP + 2);
  localparam int T_IDLE = cyc(IDLE_NS);
  localparam int SA_MAX = T_RASP + T_RC;
  localparam int SA_W   = $clog2(SA_MAX + 1);
  localparam int CNT_MAX = T_IDLE + T_RCD + T_COL + T_CP + T_RP;
  localparam int CNT_W  = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_COL, S_CPRE, S_OPEN, S_PRE} st_t;

  st_t              st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic [SA_W-1:0]  since_act;
  logic             pend, p_wr, cur_wr;
  logic [AW-1:0]    p_addr;
  logic [DQ_W-1:0]  p_data;
  logic [MA_W-1:0]  open_row;
  logic             go_act, go_col, go_pre, col_end;

  wire [MA_W-1:0] p_row = p_addr[AW-1:MA_W];
  wire [MA_W-1:0] p_col = p_addr[MA_W-1:0];
  wire hit        = pend && (p_row == open_row);
  wire act_ok     = int'(since_act) >= T_RC - 1;
  wire ras_min_ok = int'(since_act) >= T_RAS - 1;
  wire age_ok     = int'(since_act) < T_LIM;
  wire start_ok   = pend && !ref_grant && act_ok;
  wire can_col    = hit && !ref_grant && age_ok;
  wire close_want = ref_grant || pend || !age_ok || int'(cnt) >= T_IDLE - 1;

  assign req_ready = !pend && !ref_grant;
  wire accept = req_valid && req_ready;

  always_comb begin
    st_nx   = st;
    go_act  = 1'b0;
    go_col  = 1'b0;
    go_pre  = 1'b0;
    col_end = 1'b0;
    case (st)
      S_IDLE: go_act = start_ok;
      S_ACT:  go_col = int'(cnt) >= T_RCD - 1;
      S_COL:  col_end = int'(cnt) >= T_COL - 1;
      S_CPRE: if (int'(cnt) >= T_CP - 1) begin
                if (can_col) go_col = 1'b1;
                else st_nx = S_OPEN;
              end
      S_OPEN: if (can_col) go_col = 1'b1;
              else if (close_want && ras_min_ok) go_pre = 1'b1;
      S_PRE:  if (int'(cnt) >= T_RP - 1) begin
                if (start_ok) go_act = 1'b1;
                else st_nx = S_IDLE;
              end
      default: st_nx = S_IDLE;
    endcase
    if (go_act)  st_nx = S_ACT;
    if (go_col)  st_nx = S_COL;
    if (go_pre)  st_nx = S_PRE;
    if (col_end) st_nx = S_CPRE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      since_act <= SA_W'(SA_MAX);
      pend      <= 1'b0;
      p_wr      <= 1'b0;
      p_addr    <= '0;
      p_data    <= '0;
      cur_wr    <= 1'b0;
      open_row  <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      ma        <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_nx;
      rsp_valid <= 1'b0;
      if (st_nx != st) cnt <= '0;
      else if (int'(cnt) < CNT_MAX) cnt <= cnt + 1'b1;

      if (go_act) since_act <= '0;
      else if (int'(since_act) < SA_MAX) since_act <= since_act + 1'b1;

      if (accept) begin
        pend   <= 1'b1;
        p_wr   <= req_write;
        p_addr <= req_addr;
        p_data <= req_wdata;
      end

      if (go_act) begin
        ras_n    <= 1'b0;
        ma       <= p_row;
        open_row <= p_row;
      end

      if (st == S_ACT && int'(cnt) + 1 >= T_RAH) ma <= p_col;

      if (go_col) begin
        cas_n  <= 1'b0;
        ma     <= p_col;
        we_n   <= !p_wr;
        oe_n   <= p_wr;
        dq_oe  <= p_wr;
        dq_out <= p_data;
        cur_wr <= p_wr;
        pend   <= 1'b0;
      end

      if (col_end) begin
        cas_n <= 1'b1;
        we_n  <= 1'b1;
        oe_n  <= 1'b1;
        dq_oe <= 1'b0;
        if (!cur_wr) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= dq_in;
        end
      end

      if (go_pre) ras_n <= 1'b1;
    end
  end

  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);                                       // R2
  AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> int'(since_act) < T_RASP);                     // R6
  AST_WE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(we_n));             // R8
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);                                  // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                // R9
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);                                        // R11
  AST_GRANT_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && $past(ref_grant) && ras_n) |=> ras_n);      // R10

endmodule

// File: tb/page_dram_ctrl_tb.sv
`timescale 1ns/1ps
module page_dram_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ref_grant = 0;
  logic [17:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0] rsp_rdata, dq_out, dq_in;
  logic [8:0] ma;

  always #5 clk = ~clk;

  page_dram_ctrl #(.RASP_NS(2000)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_grant(ref_grant),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .ma(ma),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  int total = 0, bad = 0;
  logic [3:0] exp_q[$];
  logic [3:0] ref_mem[int];
  logic [3:0] mem[int];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] rd(ref logic [3:0] m[int], input int k);
    return m.exists(k) ? m[k] : 4'h0;
  endfunction

  // pin-level memory model and timing monitor
  int cyc_n = 0, ras_fall_at = -100, ras_rise_at = -100, cas_fall_at = -100, act_cnt = 0;
  bit prev_ras = 1, prev_cas = 1, seen_fall = 0, seen_rise = 0, first_col = 1, we_moved = 0;
  logic we_at_fall = 1;
  logic [8:0] row_lat = '0;
  logic [3:0] rd_val = '0;

  assign dq_in = (!cas_n && !oe_n) ? rd_val : 4'h0;

  always @(negedge clk) if (rst_n) begin
    cyc_n++;
    if (prev_ras && !ras_n) begin
      if (seen_fall) chk(cyc_n - ras_fall_at >= 8, "R5 ras fall spacing", cyc_n - ras_fall_at, 8);
      if (seen_rise) chk(cyc_n - ras_rise_at >= 3, "R5 precharge", cyc_n - ras_rise_at, 3);
      seen_fall = 1; ras_fall_at = cyc_n; row_lat = ma; act_cnt++; first_col = 1;
    end
    if (!prev_ras && ras_n) begin
      chk(cyc_n - ras_fall_at >= 5, "R5 ras low min", cyc_n - ras_fall_at, 5);
      chk(cyc_n - ras_fall_at <= 200, "R6 ras low max", cyc_n - ras_fall_at, 200);
      seen_rise = 1; ras_rise_at = cyc_n;
    end
    if (prev_cas && !cas_n) begin
      chk(!ras_n && cyc_n - ras_fall_at >= 2, "R2 ras to cas", cyc_n - ras_fall_at, 2);
      if (!first_col) chk(cyc_n - cas_fall_at >= 3, "R4 page cycle", cyc_n - cas_fall_at, 3);
      first_col = 0; cas_fall_at = cyc_n; we_at_fall = we_n; we_moved = 0;
      if (!we_n) begin
        chk(dq_oe && oe_n, "R8 write drive", {dq_oe, oe_n}, 3);
        mem[int'({row_lat, ma})] = dq_out;
      end else begin
        chk(!oe_n && !dq_oe, "R11 read enables", {dq_oe, oe_n}, 0);
        rd_val = rd(mem, int'({row_lat, ma}));
      end
    end
    if (!cas_n && we_n != we_at_fall) we_moved = 1;
    if (!prev_cas && cas_n) begin
      chk(cyc_n - cas_fall_at >= 3, "R4 cas low", cyc_n - cas_fall_at, 3);
      chk(!we_moved, "R8 we steady", we_moved, 0);
    end
    prev_ras = ras_n; prev_cas = cas_n;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) chk(0, "R9 unexpected response", rsp_rdata, -1);
    else begin
      logic [3:0] e;
      e = exp_q.pop_front();
      chk(rsp_rdata == e, "R9 read data", rsp_rdata, e);
    end
  end

  task automatic send(input bit wr, input logic [17:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (wr) ref_mem[int'(a)] = d;
    else exp_q.push_back(rd(ref_mem, int'(a)));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n - 1) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int a0;
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    #1;
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    rst_n = 1;
    @(negedge clk); #1;
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe, "R1 idle pins", {ras_n, cas_n, we_n, oe_n, dq_oe}, 30);
    chk(req_ready && !rsp_valid, "R1 ready and no response", {req_ready, rsp_valid}, 2);

    // R3 R8 R9: burst to one row
    a0 = act_cnt;
    for (int i = 0; i < 8; i++) send(1, {9'd5, 9'(i)}, 4'(i * 3 + 1));
    for (int i = 0; i < 8; i++) send(0, {9'd5, 9'(i)}, 4'h0);
    idle(10);
    chk(act_cnt - a0 == 1, "R3 single activation for burst", act_cnt - a0, 1);
    chk(ras_n == 0, "R7 row held while idle", ras_n, 0);
    repeat (35) @(negedge clk); #1;
    chk(ras_n == 1, "R7 row closed after idle", ras_n, 1);
    chk(exp_q.size() == 0, "R9 burst reads returned", exp_q.size(), 0);

    // R5: alternating rows
    a0 = act_cnt;
    send(1, {9'd1, 9'd3}, 4'hA);
    send(1, {9'd2, 9'd3}, 4'h5);
    send(0, {9'd1, 9'd3}, 4'h0);
    send(0, {9'd2, 9'd3}, 4'h0);
    idle(30);
    chk(act_cnt - a0 == 4, "R5 miss reopens", act_cnt - a0, 4);

    // R6: long hit run must be split
    a0 = act_cnt;
    for (int i = 0; i < 80; i++) send(i < 8, {9'd7, 9'(i % 8)}, 4'(i + 2));
    idle(40);
    chk(act_cnt - a0 >= 2, "R6 run split across activations", act_cnt - a0, 2);

    // R10: refresh grant
    send(1, {9'd9, 9'd17}, 4'hC);
    idle(3);
    chk(ras_n == 0, "R10 row open before grant", ras_n, 0);
    @(negedge clk); ref_grant = 1; #1;
    @(negedge clk); #1;
    chk(req_ready == 0, "R10 ready low in grant", req_ready, 0);
    repeat (11) @(negedge clk); #1;
    chk(ras_n == 1, "R10 row closed for grant", ras_n, 1);
    a0 = act_cnt;
    repeat (20) @(negedge clk); #1;
    chk(ras_n == 1 && act_cnt == a0, "R10 no activation in grant", act_cnt - a0, 0);
    ref_grant = 0;
    send(0, {9'd9, 9'd17}, 4'h0);
    idle(30);
    chk(exp_q.size() == 0, "R10 resumed read returned", exp_q.size(), 0);

    // mixed traffic over three rows
    lcg = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      send(lcg[20], {9'(lcg[25:24] % 3 + 20), 6'd0, lcg[18:16]}, lcg[11:8]);
    end
    idle(60);
    chk(exp_q.size() == 0, "R9 all responses in order", exp_q.size(), 0);
    finish_run();
  end
endmodule